// File: doc/BRIEF.md
# Status Register and Write-Protection Unit

This block holds the 8-bit status register of a serial memory and decides, for each array address, whether a write is allowed. The byte carries a status-lock bit, two region-select bits, a write-enable latch and four free user bits. The surrounding serial engine decodes commands. It hands this unit one-cycle strobes for enable, disable and status-load, together with the data byte and the current target address.

The unit evaluates protection from two sources. One is the latch and the region bits, the software mode. The other is the status-lock bit combined with the external write-protect pin, the hardware mode. The pin is captured once at the start of each transaction. The register reads back at all times on `status_o`. The write permit `write_ok_o` is a combinational function of the stored state and the address.

Top module: `status_protect_unit`

## Requirements
- R1: After reset `status_o` is 8'h00 and `write_ok_o` is 0 for every address.
- R2: A `wren_i` strobe sets status bit 1 (the enable latch) at the next clock edge. A `wrdi_i` strobe clears it. When both strobes arrive in the same cycle, clearing wins.
- R3: `write_ok_o` is 0 whenever status bit 1 is 0.
- R4: A `wrsr_i` strobe while status bit 1 is 0 leaves the whole status byte unchanged.
- R5: With status bit 1 at 1 and status bit 7 (lock) at 0, `wrsr_i` loads bits 7:2 and bit 0 from `wrsr_data_i` at the next edge, whatever the captured pin level.
- R6: With bit 7 at 1, `wrsr_i` is accepted only if the captured pin level is high. With the captured level low, the byte is unchanged.
- R7: `wp_i` is captured on the cycle `txn_start_i` is high. Later changes of `wp_i` have no effect until the next `txn_start_i`.
- R8: Bit 1 of `wrsr_data_i` is ignored. A status load never changes the enable latch.
- R9: Bits 3:2 select the protected region of the 19-bit address space. 00 protects nothing. 01 protects addresses at or above 19'h60000. 10 protects addresses at or above 19'h40000. 11 protects every address.
- R10: Bits 6, 5, 4 and 0 store and read back what was loaded and have no effect on `write_ok_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up) |
| txn_start_i | input | 1 | Transaction start strobe, captures `wp_i` |
| wp_i | input | 1 | Write-protect pin level |
| wren_i | input | 1 | Enable-latch set strobe |
| wrdi_i | input | 1 | Enable-latch clear strobe |
| wrsr_i | input | 1 | Status-load strobe |
| wrsr_data_i | input | 8 | Status byte to load |
| addr_i | input | 19 | Target array address |
| status_o | output | 8 | Status byte read-back |
| write_ok_o | output | 1 | Write permitted at `addr_i` |

## Verification
A wrong enable latch or lock bit shows on `status_o` one edge after the strobe that set it. The same fault then shows in the response to the next status load, or on `write_ok_o` at once. A wrongly captured pin level stays hidden until a status load meets a set lock bit. The bench therefore holds transactions in which the pin moves after capture and loads are attempted under each combination. Region decoding faults show combinationally on `write_ok_o`. The addresses just below and at each boundary expose off-by-one thresholds.

// File: rtl/spu_pkg.sv
package spu_pkg;
  localparam int unsigned STAT_W  = 8;
  localparam int unsigned LOCK_B  = 7;
  localparam int unsigned RGN_HI  = 3;
  localparam int unsigned RGN_LO  = 2;
  localparam int unsigned WEL_B   = 1;

  typedef enum logic [1:0] {
    RGN_NONE    = 2'b00,
    RGN_QUARTER = 2'b01,
    RGN_HALF    = 2'b10,
    RGN_ALL     = 2'b11
  } rgn_e;
endpackage

// File: rtl/spu_wp_capture.sv
module spu_wp_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic wp_i,
  output logic wp_held_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wp_held_o <= 1'b0;
    else if (start_i) wp_held_o <= wp_i;
  end
endmodule

// File: rtl/spu_status_reg.sv
module spu_status_reg
  import spu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [STAT_W-1:0] data_i,
  input  logic              wp_held_i,
  output logic [STAT_W-1:0] status_o
);
  logic              wel_q;
  logic [STAT_W-1:0] bits_q;
  logic              load_ok;

  // lock bit set demands captured pin high
  assign load_ok = wrsr_i && wel_q && (!bits_q[LOCK_B] || wp_held_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wel_q <= 1'b0;
    else if (wrdi_i) wel_q <= 1'b0;
    else if (wren_i) wel_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bits_q <= '0;
    else if (load_ok) bits_q <= data_i & ~(STAT_W'(1) << WEL_B);
  end

  always_comb begin
    status_o        = bits_q;
    status_o[WEL_B] = wel_q;
  end
endmodule

// File: rtl/spu_region_decode.sv
module spu_region_decode
  import spu_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  rgn_e              rgn_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              protected_o
);
  localparam int unsigned TOP = ADDR_W - 1;

  logic in_half, in_quarter;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign in_half    = addr_i[TOP];
      assign in_quarter = addr_i[TOP] & addr_i[TOP-1];
    end else begin : g_narrow
      assign in_half    = addr_i[TOP];
      assign in_quarter = addr_i[TOP];
    end
  endgenerate

  always_comb begin
    unique case (rgn_i)
      RGN_NONE:    protected_o = 1'b0;
      RGN_QUARTER: protected_o = in_quarter;
      RGN_HALF:    protected_o = in_half;
      default:     protected_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/status_protect_unit.sv
module status_protect_unit
  import spu_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              txn_start_i,
  input  logic              wp_i,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        status_o,
  output logic              write_ok_o
);
  logic wp_held;
  logic in_prot;
  rgn_e rgn;

  spu_wp_capture u_wp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (txn_start_i),
    .wp_i      (wp_i),
    .wp_held_o (wp_held)
  );

  spu_status_reg u_sr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wren_i    (wren_i),
    .wrdi_i    (wrdi_i),
    .wrsr_i    (wrsr_i),
    .data_i    (wrsr_data_i),
    .wp_held_i (wp_held),
    .status_o  (status_o)
  );

  assign rgn = rgn_e'(status_o[RGN_HI:RGN_LO]);

  spu_region_decode #(.ADDR_W(ADDR_W)) u_rgn (
    .rgn_i       (rgn),
    .addr_i      (addr_i),
    .protected_o (in_prot)
  );

  assign write_ok_o = status_o[WEL_B] & ~in_prot;
endmodule

// File: rtl/status_protect_unit_chk.sv
module status_protect_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       txn_start_i,
  input logic       wren_i,
  input logic       wrdi_i,
  input logic       wrsr_i,
  input logic [7:0] status_o,
  input logic       write_ok_o,
  input logic       wp_held
);
  assert_wel_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrdi_i |=> !status_o[1]);
  assert_wel_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wren_i && !wrdi_i |=> status_o[1]);
  assert_permit_needs_wel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_ok_o |-> status_o[1]);
  assert_no_load_unlatched_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrsr_i && !status_o[1] |=> $stable(status_o[7:2]) && $stable(status_o[0]));
  assert_hw_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrsr_i && status_o[7] && !wp_held |=> $stable(status_o[7:2]) && $stable(status_o[0]));
  assert_wp_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txn_start_i |=> $stable(wp_held));
  assert_wel_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrsr_i && !wren_i && !wrdi_i |=> $stable(status_o[1]));
  assert_all_protected_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[3:2] == 2'b11 |-> !write_ok_o);
  assert_bits_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrsr_i |=> $stable(status_o[7:2]) && $stable(status_o[0]));
endmodule

bind status_protect_unit status_protect_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .txn_start_i (txn_start_i),
  .wren_i      (wren_i),
  .wrdi_i      (wrdi_i),
  .wrsr_i      (wrsr_i),
  .status_o    (status_o),
  .write_ok_o  (write_ok_o),
  .wp_held     (wp_held)
);

// File: tb/test_status_protect_unit.sv
module test_status_protect_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {expected permit, status byte to load, address}
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b1, 8'h00, 19'h7FFFF},
    {1'b1, 8'h04, 19'h5FFFF},
    {1'b0, 8'h04, 19'h60000},
    {1'b1, 8'h08, 19'h3FFFF},
    {1'b0, 8'h08, 19'h40000},
    {1'b0, 8'h0C, 19'h00000},
    {1'b1, 8'hF1, 19'h7FFFF},
    {1'b1, 8'h72, 19'h12345}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        txn_start_i = 1'b0;
  logic        wp_i = 1'b0;
  logic        wren_i = 1'b0;
  logic        wrdi_i = 1'b0;
  logic        wrsr_i = 1'b0;
  logic [7:0]  wrsr_data_i = 8'h00;
  logic [18:0] addr_i = '0;
  logic [7:0]  status_o;
  logic        write_ok_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  status_protect_unit i_status_protect_unit (
    .clk_i, .rst_ni, .txn_start_i, .wp_i, .wren_i, .wrdi_i,
    .wrsr_i, .wrsr_data_i, .addr_i, .status_o, .write_ok_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic en, input logic dis, input logic sr, input logic [7:0] d);
    @(negedge clk_i);
    wren_i = en; wrdi_i = dis; wrsr_i = sr; wrsr_data_i = d;
    @(negedge clk_i);
    wren_i = 1'b0; wrdi_i = 1'b0; wrsr_i = 1'b0;
  endtask

  task automatic start(input logic wp);
    @(negedge clk_i);
    wp_i = wp; txn_start_i = 1'b1;
    @(negedge clk_i);
    txn_start_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 status", status_o, 8'h00);
    addr_i = 19'h00000;
    #1 check("R1 permit", write_ok_o, 0);
    rst_ni = 1'b1;

    start(1'b1);
    cmd(1, 0, 0, 8'h00);
    check("R2 wren", status_o, 8'h02);

    for (int i = 0; i < NVEC; i++) begin
      addr_i = VEC[i][18:0];
      cmd(0, 0, 1, VEC[i][26:19]);
      check("R5/R8/R10 status", status_o, (VEC[i][26:19] & 8'hFD) | 8'h02);
      check("R9 permit", write_ok_o, VEC[i][27]);
    end

    // hardware lock
    cmd(0, 0, 1, 8'h80);
    check("R5 lock set", status_o, 8'h82);
    start(1'b0);
    cmd(0, 0, 1, 8'h0C);
    check("R6 locked", status_o, 8'h82);
    addr_i = 19'h7FFFF;
    #1 check("R10 permit", write_ok_o, 1);
    wp_i = 1'b1;
    cmd(0, 0, 1, 8'h0C);
    check("R7 held low", status_o, 8'h82);
    start(1'b1);
    cmd(0, 0, 1, 8'h0C);
    check("R6 unlocked", status_o, 8'h0E);

    // software mode ignores pin
    start(1'b0);
    cmd(0, 0, 1, 8'h84);
    check("R5 wp low", status_o, 8'h86);
    start(1'b1);
    cmd(0, 0, 1, 8'h00);
    check("R5 clear", status_o, 8'h02);

    cmd(0, 1, 0, 8'h00);
    check("R2 wrdi", status_o, 8'h00);
    addr_i = 19'h00000;
    #1 check("R3 permit", write_ok_o, 0);
    cmd(0, 0, 1, 8'h0C);
    check("R4 ignored", status_o, 8'h00);
    cmd(1, 0, 0, 8'h00);
    check("R2 wren again", status_o, 8'h02);
    cmd(1, 1, 0, 8'h00);
    check("R2 both", status_o, 8'h00);

    cmd(1, 0, 1, 8'hFF);
    check("R4 same cycle", status_o, 8'h02);
    cmd(0, 0, 1, 8'h71);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1 check("R1 async", status_o, 8'h00);
    check("R1 permit2", write_ok_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule